// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores incoming Ethernet frames in a circular buffer held in local packet RAM. The ring is built from 256-byte pages. Three plain inputs give its first page, its end page and the host's boundary page. The block owns the current-page register, and the host can also load that register. Frame bytes arrive on a valid/ready byte stream. The block drives a simple byte-wide RAM write port.

The first byte of a frame decides whether the frame is taken. The frame is refused if the controller is stopped or if the free space ahead of the current page is too small. A refused frame is still drained from the stream, but nothing is written. An accepted frame is written from offset 4 of the current page onward, and the address wraps from the end of the ring back to its start. A short frame is padded with zero bytes. A 4-byte header is then written at offset 0 of the page. Finally the current page moves past the frame and a sticky receive interrupt flag is set.

Back-pressure rules: a byte moves on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high while the block is idle, while it is taking data and while it is draining a refused frame. It is low while padding and header bytes are written. `busy` is high from the first stored byte until the frame is committed, so a new frame is never taken before the previous one is complete.

Top module: `rx_ring_writer`

## Requirements
- R1: RAM byte address = page × 256 + offset. `cur_wr` loads `cur_wdata` into `cur_pg` on the next edge. An accepted frame of stored size L (after padding) makes exactly L + 4 RAM writes.
- R2: Free bytes are (bnd − cur) × 256 when cur < bnd. Otherwise they are (stop − start − (cur − bnd)) × 256. When free < 1518 the frame is refused: its bytes are consumed, nothing is written, and `cur_pg` and `rx_int` are unchanged.
- R3: While `stopped` is high, a frame that starts is refused in the same way as in R2.
- R4: Frame byte i is written at address cur × 256 + 4 + i, with the wrap of R7.
- R5: A frame shorter than 60 bytes is padded with zero bytes up to a stored size of 60.
- R6: The header is written at cur × 256 + 0..3 as: status, next page, length bits 7:0, length bits 15:8. Length = stored size + 4.
- R7: When the next write address equals stop × 256, it becomes start × 256, mid-frame if needed.
- R8: next = cur + ceil((length + 4) / 256). If next ≥ stop, then next = next − (stop − start).
- R9: The status byte is 0x01. Bit 5 (value 0x20) is also set when bit 0 of the frame's first byte is 1.
- R10: At commit, `cur_pg` takes the next page and `rx_int` is set. `rx_int_clr` clears it. Both are 0 after reset.
- R11: After the last byte of an accepted frame, `busy` is high and `in_ready` is low until the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stopped | input | 1 | Controller stopped; frames are refused |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page just past the ring |
| bnd_pg | input | 8 | Host boundary page |
| cur_wr | input | 1 | Host load of the current page |
| cur_wdata | input | 8 | Value for the current page |
| cur_pg | output | 8 | Current page register |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_ready | output | 1 | Byte accepted on this edge if valid |
| busy | output | 1 | Frame storage in progress |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| rx_int | output | 1 | Sticky receive interrupt flag |
| rx_int_clr | input | 1 | Clear for rx_int |

## Verification
Every RAM write is registered, so the write for a byte accepted on edge k appears on the port just after edge k. The bench records writes on the falling edge, so each write pulse is recorded exactly once. Padding takes one cycle per zero byte and the header takes four cycles. The commit (new `cur_pg` and `rx_int` set) happens on the same edge as the last header write. For this reason the bench waits until `busy` falls before it compares memory, page and flag against values it computes from the frame size and ring settings. Host loads and flag clears are driven on one falling edge and checked on the next one.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int LEN_W   = 16;
  localparam int HDR_LEN = 4;
  typedef enum logic [2:0] {S_IDLE, S_DATA, S_DROP, S_PAD, S_HEAD} rxw_state_e;
endpackage

// File: rtl/rxw_space.sv
module rxw_space #(
  parameter int PAGE_W   = 8,
  parameter int PAGE_SH  = 8,
  parameter int MIN_FREE = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  output logic              room_ok
);
  localparam int SW = PAGE_W + PAGE_SH + 3;
  logic signed [SW-1:0] ring_pg, free_pg, free_b;

  always_comb begin
    ring_pg = $signed(SW'(stop_pg)) - $signed(SW'(start_pg));
    if (cur_pg < bnd_pg) free_pg = $signed(SW'(bnd_pg)) - $signed(SW'(cur_pg));
    else free_pg = ring_pg - ($signed(SW'(cur_pg)) - $signed(SW'(bnd_pg)));
    free_b  = free_pg <<< PAGE_SH;
    room_ok = free_b >= $signed(SW'(MIN_FREE));
  end

  // R2: an empty ring (cur equals boundary) that is large enough always has room
  p_empty_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pg == bnd_pg && ((ring_pg <<< PAGE_SH) >= $signed(SW'(MIN_FREE)))) |-> room_ok);
endmodule

// File: rtl/rxw_wrap.sv
module rxw_wrap #(
  parameter int PAGE_W  = 8,
  parameter int PAGE_SH = 8
) (
  input  logic [PAGE_W+PAGE_SH-1:0] a_in,
  input  logic [PAGE_W-1:0]         start_pg,
  input  logic [PAGE_W-1:0]         stop_pg,
  output logic [PAGE_W+PAGE_SH-1:0] a_out
);
  localparam int AW = PAGE_W + PAGE_SH;
  logic [AW-1:0] inc;
  always_comb begin
    inc = a_in + AW'(1);
    if (inc == (AW'(stop_pg) << PAGE_SH)) a_out = AW'(start_pg) << PAGE_SH;
    else a_out = inc;
  end
endmodule

// File: rtl/rxw_next.sv
module rxw_next #(
  parameter int PAGE_W  = 8,
  parameter int PAGE_SH = 8,
  parameter int LEN_W   = 16
) (
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [LEN_W-1:0]  len,
  output logic [PAGE_W-1:0] nxt_pg
);
  localparam int NW = ((LEN_W > PAGE_W) ? LEN_W : PAGE_W) + 2;
  localparam int RND = 4 + (1 << PAGE_SH) - 1;
  logic [NW-1:0] pages, sum;
  always_comb begin
    pages = (NW'(len) + NW'(RND)) >> PAGE_SH;
    sum   = NW'(base_pg) + pages;
    if (sum >= NW'(stop_pg)) sum = sum - (NW'(stop_pg) - NW'(start_pg));
    nxt_pg = sum[PAGE_W-1:0];
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PAGE_W    = 8,
  parameter int PAGE_SH   = 8,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stopped,
  input  logic [PAGE_W-1:0]         start_pg,
  input  logic [PAGE_W-1:0]         stop_pg,
  input  logic [PAGE_W-1:0]         bnd_pg,
  input  logic                      cur_wr,
  input  logic [PAGE_W-1:0]         cur_wdata,
  output logic [PAGE_W-1:0]         cur_pg,
  input  logic                      in_valid,
  input  logic [7:0]                in_data,
  input  logic                      in_last,
  output logic                      in_ready,
  output logic                      busy,
  output logic                      ram_we,
  output logic [PAGE_W+PAGE_SH-1:0] ram_addr,
  output logic [7:0]                ram_wdata,
  output logic                      rx_int,
  input  logic                      rx_int_clr
);
  import rxw_pkg::*;
  localparam int AW       = PAGE_W + PAGE_SH;
  localparam int MIN_FREE = MAX_FRAME + HDR_LEN;

  rxw_state_e        st;
  logic [AW-1:0]     ptr, wr_addr, ptr_nxt, first_addr, hdr_base;
  logic [LEN_W-1:0]  cnt, cnt_inc, len_hdr;
  logic [PAGE_W-1:0] fr_pg, nxt_pg;
  logic [7:0]        stat, hdr_byte;
  logic [1:0]        hidx;
  logic              room_ok, take, commit;

  rxw_space #(.PAGE_W(PAGE_W), .PAGE_SH(PAGE_SH), .MIN_FREE(MIN_FREE)) u_space (
    .clk(clk), .rst_n(rst_n), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .cur_pg(cur_pg), .room_ok(room_ok));

  rxw_wrap #(.PAGE_W(PAGE_W), .PAGE_SH(PAGE_SH)) u_wrap (
    .a_in(wr_addr), .start_pg(start_pg), .stop_pg(stop_pg), .a_out(ptr_nxt));

  rxw_next #(.PAGE_W(PAGE_W), .PAGE_SH(PAGE_SH), .LEN_W(LEN_W)) u_next (
    .start_pg(start_pg), .stop_pg(stop_pg), .base_pg(fr_pg), .len(len_hdr),
    .nxt_pg(nxt_pg));

  always_comb begin
    in_ready   = (st == S_IDLE) || (st == S_DATA) || (st == S_DROP);
    busy       = (st != S_IDLE);
    take       = in_valid && in_ready;
    first_addr = (AW'(cur_pg) << PAGE_SH) + AW'(HDR_LEN);
    hdr_base   = AW'(fr_pg) << PAGE_SH;
    wr_addr    = (st == S_IDLE) ? first_addr : ptr;
    cnt_inc    = (st == S_IDLE) ? LEN_W'(1) : ((&cnt) ? cnt : cnt + LEN_W'(1));
    len_hdr    = cnt + LEN_W'(HDR_LEN);
    commit     = (st == S_HEAD) && (hidx == 2'd3);
    case (hidx)
      2'd0:    hdr_byte = stat;
      2'd1:    hdr_byte = 8'(nxt_pg);
      2'd2:    hdr_byte = len_hdr[7:0];
      default: hdr_byte = len_hdr[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; cnt <= '0; fr_pg <= '0; stat <= '0; hidx <= '0;
      ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      cur_pg <= '0; rx_int <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (!stopped && room_ok) begin
            ram_we <= 1'b1; ram_addr <= wr_addr; ram_wdata <= in_data;
            ptr <= ptr_nxt; cnt <= cnt_inc; fr_pg <= cur_pg;
            stat <= {2'b00, in_data[0], 4'b0000, 1'b1};
            if (in_last) st <= (cnt_inc < LEN_W'(MIN_FRAME)) ? S_PAD : S_HEAD;
            else st <= S_DATA;
          end else if (!in_last) begin
            st <= S_DROP;
          end
        end
        S_DATA: if (take) begin
          ram_we <= 1'b1; ram_addr <= wr_addr; ram_wdata <= in_data;
          ptr <= ptr_nxt; cnt <= cnt_inc;
          if (in_last) st <= (cnt_inc < LEN_W'(MIN_FRAME)) ? S_PAD : S_HEAD;
        end
        S_DROP: if (take && in_last) st <= S_IDLE;
        S_PAD: begin
          ram_we <= 1'b1; ram_addr <= wr_addr; ram_wdata <= 8'h00;
          ptr <= ptr_nxt; cnt <= cnt_inc;
          if (cnt_inc >= LEN_W'(MIN_FRAME)) st <= S_HEAD;
        end
        S_HEAD: begin
          ram_we <= 1'b1; ram_addr <= hdr_base + AW'(hidx); ram_wdata <= hdr_byte;
          hidx <= hidx + 2'd1;
          if (commit) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (commit) cur_pg <= nxt_pg;
      else if (cur_wr) cur_pg <= cur_wdata;
      if (commit) rx_int <= 1'b1;
      else if (rx_int_clr) rx_int <= 1'b0;
    end
  end

  // R3: a frame starting while stopped produces no RAM write
  p_no_write_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && in_valid && stopped) |=> !ram_we);
  // R5: each padding cycle writes a zero byte
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAD) |=> (ram_we && ram_wdata == 8'h00));
  // R10: the fourth header byte completes the frame and raises the flag
  p_commit_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HEAD && hidx == 2'd3) |=> (rx_int && !busy));
  // R11: the current page holds while a frame is in flight and the host is quiet
  p_cur_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur_wr && !(st == S_HEAD && hidx == 2'd3)) |=> $stable(cur_pg));
endmodule

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  logic clk = 1'b0, rst_n = 1'b0, stopped = 1'b0;
  logic [7:0] start_pg = 8'h40, stop_pg = 8'h60, bnd_pg = 8'h40;
  logic cur_wr = 1'b0, in_valid = 1'b0, in_last = 1'b0, rx_int_clr = 1'b0;
  logic [7:0] cur_wdata = '0, in_data = '0;
  logic [7:0] cur_pg, ram_wdata;
  logic [15:0] ram_addr;
  logic in_ready, busy, ram_we, rx_int;
  int errors = 0, checks = 0, wcount = 0;
  logic [7:0] mem [int];

  always #10 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .start_pg(start_pg),
    .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_wr(cur_wr), .cur_wdata(cur_wdata),
    .cur_pg(cur_pg), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .rx_int(rx_int), .rx_int_clr(rx_int_clr));

  always @(negedge clk) if (ram_we) begin mem[int'(ram_addr)] = ram_wdata; wcount++; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp); end
  endtask

  function automatic int fbyte(input int i, input int b0, input int seed);
    return (i == 0) ? b0 : ((seed + i * 7) & 255);
  endfunction

  function automatic int rd(input int a);
    return mem.exists(a) ? int'(mem[a]) : -1;
  endfunction

  task automatic set_cur(input int p);
    @(negedge clk); cur_wr = 1'b1; cur_wdata = 8'(p);
    @(negedge clk); cur_wr = 1'b0; #1;
    chk(cur_pg == 8'(p), "R1 host page load", cur_pg, p);
  endtask

  task automatic clr_int();
    @(negedge clk); rx_int_clr = 1'b1;
    @(negedge clk); rx_int_clr = 1'b0; #1;
    chk(rx_int == 1'b0, "R10 flag clear", rx_int, 0);
  endtask

  task automatic send(input int n, input int b0, input int seed, input bit exp_acc);
    int i = 0;
    mem.delete(); wcount = 0;
    while (i < n) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'(fbyte(i, b0, seed)); in_last = (i == n - 1);
      #1; if (in_ready) i++;
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; #1;
    if (exp_acc) begin
      chk(busy && !in_ready, "R11 hold after last byte", {busy, in_ready}, 2);
      for (int k = 0; k < 300 && busy; k++) begin @(negedge clk); #1; end
    end
    @(negedge clk); #1;
  endtask

  task automatic frame_ok(input int n, input int b0, input int seed);
    int c0, L, len, nx, a, derr, perr, stv;
    c0 = int'(cur_pg);
    send(n, b0, seed, 1'b1);
    L = (n < 60) ? 60 : n; len = L + 4;
    nx = c0 + ((len + 4 + 255) >> 8);
    if (nx >= int'(stop_pg)) nx -= int'(stop_pg) - int'(start_pg);
    stv = 1 | (((b0 & 1) != 0) ? 32 : 0);
    chk(wcount == len, "R1 write count", wcount, len);
    chk(rd(c0 * 256) == stv, "R9 status byte", rd(c0 * 256), stv);
    chk(rd(c0 * 256 + 1) == nx, "R6 R8 header next page", rd(c0 * 256 + 1), nx);
    chk(rd(c0 * 256 + 2) == (len & 255), "R6 header length low", rd(c0 * 256 + 2), len & 255);
    chk(rd(c0 * 256 + 3) == (len >> 8), "R6 header length high", rd(c0 * 256 + 3), len >> 8);
    derr = 0; perr = 0; a = c0 * 256 + 4;
    for (int i = 0; i < L; i++) begin
      if (i < n) begin if (rd(a) != fbyte(i, b0, seed)) derr++; end
      else if (rd(a) != 0) perr++;
      a++; if (a == int'(stop_pg) * 256) a = int'(start_pg) * 256;
    end
    chk(derr == 0, "R4 R7 frame data placement", derr, 0);
    chk(perr == 0, "R5 zero padding", perr, 0);
    chk(cur_pg == 8'(nx), "R10 current page advance", cur_pg, nx);
    chk(rx_int == 1'b1, "R10 flag set", rx_int, 1);
  endtask

  task automatic frame_refused(input int n, input string req);
    int c0 = int'(cur_pg);
    send(n, 1, 3, 1'b0);
    chk(wcount == 0, req, wcount, 0);
    chk(cur_pg == 8'(c0), req, cur_pg, c0);
    chk(rx_int == 1'b0, req, rx_int, 0);
  endtask

  initial begin
    int sizes[9] = '{1, 59, 60, 61, 247, 248, 249, 500, 1514};
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    chk(cur_pg == 0 && rx_int == 0, "R10 reset state", {cur_pg, rx_int}, 0);
    chk(!busy && in_ready && !ram_we, "R11 idle after reset", {busy, in_ready, ram_we}, 2);
    set_cur(8'h40);
    foreach (sizes[k]) begin
      bnd_pg = cur_pg;
      frame_ok(sizes[k], ((k % 2) != 0) ? (8'h01 | (k * 2)) : ((k * 6) & 8'hFE), k * 13);
      clr_int();
    end
    // R7 R8: data wraps mid-frame and the next page wraps past the end
    set_cur(8'h5E); bnd_pg = 8'h5E;
    frame_ok(700, 8'hFF, 5); clr_int();
    // R2: boundary ahead of current page
    set_cur(8'h48); bnd_pg = 8'h4D;
    frame_refused(100, "R2 refuse 5 free pages");
    bnd_pg = 8'h4E;
    frame_ok(100, 8'h02, 9); clr_int();
    // R2: boundary behind current page
    set_cur(8'h5D); bnd_pg = 8'h42;
    frame_refused(100, "R2 refuse wrapped 5 free pages");
    bnd_pg = 8'h43;
    frame_ok(100, 8'h11, 4); clr_int();
    // R3: stopped controller
    bnd_pg = cur_pg; stopped = 1'b1;
    frame_refused(80, "R3 refuse while stopped");
    stopped = 1'b0;
    frame_ok(80, 8'h00, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule